// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block collects sixteen interrupt sources into one status word and two processor interrupt lines: a fast-interrupt output (FIQ) and a normal interrupt output (IRQ). A processor reads the status word to find which source is active, and clears latched sources by pulsing end-of-interrupt strobes. Sources come in three kinds. Pin-following sources mirror an external active-low pin after synchronisation. Latched sources hold until their own strobe clears them. Two slow sources, battery low and media change, pass through a deglitcher that samples at a 16 kHz enable.

A 64 Hz tick enable sets a tick interrupt. If the tick is still pending when the next tick arrives, a watchdog bit is raised. A standby input holds the battery-low and watchdog bits inactive. All outputs are registered. The status word, FIQ and IRQ all change on the same clock edge.

Top module: `intr_status_agg`

## Requirements
- R1: Status bit positions: 0 external FIQ, 1 battery low, 2 watchdog, 3 media change, 4 codec, 5/6/7 external interrupts 1/2/3, 8 timer 1, 9 timer 2, 10 RTC match, 11 tick, 12 UART transmit, 13 UART receive, 14 UART modem, 15 serial end-of-transfer. Bits 31 to 16 always read 0.
- R2: Bit 0 is set exactly while `fiq_n` is low after synchronisation. It is not latched.
- R3: Bits 5 to 7 follow `ext_irq_n[0..2]` inverted, and each clears when its pin returns high.
- R4: The battery condition is `ext_supply_n` high AND `batt_good` low. Either input alone raises nothing.
- R5: The battery and media inputs change their filtered value only when two consecutive samples taken on `slow_tick` agree. A value seen in a single sample is rejected.
- R6: A rising edge of the filtered `media_n` latches bit 3. The bit stays set after further samples and clears only on `eoi[1]`.
- R7: The filtered battery condition latches bit 1. The bit stays set after the condition ends and clears on `eoi[0]`.
- R8: `hz_tick` sets bit 11. An `hz_tick` that arrives while bit 11 is still pending sets bit 2. `eoi[3]` clears both bits.
- R9: While `standby` is high, bits 1 and 2 are held at 0, and `hz_tick` cannot set bit 2.
- R10: Pulses on `codec_set`, `tmr1_set`, `tmr2_set` and `rtc_set` latch bits 4, 8, 9 and 10. The strobes `eoi[2]`, `eoi[4]`, `eoi[5]` and `eoi[6]` clear them. A set and a clear in the same cycle leave the bit set.
- R11: Bits 12 to 15 follow `uart_tx_irq`, `uart_rx_irq`, `uart_ms_irq` and `ssi_eot_irq`.
- R12: `fiq` is the OR of status bits 0 to 3. `irq` is the OR of bits 4 to 15. Both are registered together with the status word.
- R13: During and after reset, with idle inputs, the status word is 0 and both `fiq` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle 16 kHz sample enable for the deglitchers |
| hz_tick | input | 1 | One-cycle 64 Hz tick enable |
| standby | input | 1 | Standby state; suppresses battery and watchdog |
| fiq_n | input | 1 | External fast-interrupt pin, active low |
| ext_irq_n | input | 3 | External interrupt pins 1 to 3, active low |
| ext_supply_n | input | 1 | High when no external supply is present |
| batt_good | input | 1 | Battery-OK pin, low means battery low |
| media_n | input | 1 | Media-change pin |
| codec_set | input | 1 | Codec FIFO event pulse |
| tmr1_set | input | 1 | Timer 1 overflow pulse |
| tmr2_set | input | 1 | Timer 2 overflow pulse |
| rtc_set | input | 1 | RTC match pulse |
| uart_tx_irq | input | 1 | UART transmit level request |
| uart_rx_irq | input | 1 | UART receive level request |
| uart_ms_irq | input | 1 | UART modem-status level request |
| ssi_eot_irq | input | 1 | Serial end-of-transfer level request |
| eoi | input | 7 | End-of-interrupt strobes: 0 battery, 1 media, 2 codec, 3 tick and watchdog, 4 timer 1, 5 timer 2, 6 RTC |
| status | output | 32 | Registered interrupt status word |
| fiq | output | 1 | Fast interrupt request |
| irq | output | 1 | Normal interrupt request |

## Verification
The hardest cases to reach from the ports are those gated by the 16 kHz sampler: a change that lasts exactly one sample and must vanish, and a media edge that must fire only on the low-to-high transition of the filtered value. The bench drives `slow_tick` itself. It places single pulses around pin changes so that the number of samples that see each value is known exactly. The watchdog path needs two ticks with no clear between them. It is tested again with standby raised while the tick is still pending.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
  localparam int STAT_W = 16;
  localparam int BUS_W  = 32;
  localparam int NUM_EXT = 3;
  localparam int NUM_LAT = 7;

  // status bit positions
  localparam int B_FIQ   = 0;
  localparam int B_BATT  = 1;
  localparam int B_WDOG  = 2;
  localparam int B_MEDIA = 3;
  localparam int B_CODEC = 4;
  localparam int B_EXT1  = 5;
  localparam int B_TMR1  = 8;
  localparam int B_TMR2  = 9;
  localparam int B_RTC   = 10;
  localparam int B_TICK  = 11;
  localparam int B_UTX   = 12;
  localparam int B_URX   = 13;
  localparam int B_UMS   = 14;
  localparam int B_SSI   = 15;
  localparam int B_FIQ_TOP = B_MEDIA;

  // latch / strobe index
  localparam int E_BATT  = 0;
  localparam int E_MEDIA = 1;
  localparam int E_CODEC = 2;
  localparam int E_TICK  = 3;
  localparam int E_TMR1  = 4;
  localparam int E_TMR2  = 5;
  localparam int E_RTC   = 6;

  // synchronised pin vector layout
  localparam int P_FIQ    = 0;
  localparam int P_EXT    = 1;
  localparam int P_SUPPLY = P_EXT + NUM_EXT;
  localparam int P_BGOOD  = P_SUPPLY + 1;
  localparam int P_MEDIA  = P_BGOOD + 1;
  localparam int PIN_W    = P_MEDIA + 1;
endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
  parameter int W = 1,
  parameter int DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) stg[k] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/intr_deglitch.sv
module intr_deglitch #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic d,
  output logic lvl,
  output logic rise
);
  logic smp_q, lvl_q, rise_q;
  logic agree;

  assign agree = (d == smp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q  <= RST_VAL;
      lvl_q  <= RST_VAL;
      rise_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      if (en) begin
        smp_q <= d;
        if (agree) begin
          lvl_q  <= d;
          rise_q <= d & ~lvl_q;
        end
      end
    end
  end

  assign lvl  = lvl_q;
  assign rise = rise_q;

  // R5
  hold_between_samples_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(lvl_q));
endmodule

// File: rtl/intr_latch.sv
module intr_latch #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] hold_off,
  output logic [N-1:0] q
);
  logic [N-1:0] q_r;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || hold_off[i]) q_r[i] <= 1'b0;
      else if (set[i])        q_r[i] <= 1'b1;
      else if (clr[i])        q_r[i] <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (set[i] && !hold_off[i]) |=> q_r[i]);
  end

  assign q = q_r;
endmodule

// File: rtl/intr_status_agg.sv
module intr_status_agg
  import intr_agg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slow_tick,
  input  logic               hz_tick,
  input  logic               standby,
  input  logic               fiq_n,
  input  logic [NUM_EXT-1:0] ext_irq_n,
  input  logic               ext_supply_n,
  input  logic               batt_good,
  input  logic               media_n,
  input  logic               codec_set,
  input  logic               tmr1_set,
  input  logic               tmr2_set,
  input  logic               rtc_set,
  input  logic               uart_tx_irq,
  input  logic               uart_rx_irq,
  input  logic               uart_ms_irq,
  input  logic               ssi_eot_irq,
  input  logic [NUM_LAT-1:0] eoi,
  output logic [BUS_W-1:0]   status,
  output logic               fiq,
  output logic               irq
);
  localparam logic [PIN_W-1:0] PIN_RST = {1'b1, 1'b1, 1'b0, {NUM_EXT{1'b1}}, 1'b1};

  logic [PIN_W-1:0]   pin_raw, pin_s;
  logic               batt_cond;
  logic               batt_lvl, batt_rise;
  logic               med_lvl, med_rise;
  logic [NUM_LAT-1:0] lat_set, lat_hold, lat_q;
  logic               wdog_set, wdog_q;
  logic [STAT_W-1:0]  raw, status_q;
  logic               fiq_q, irq_q;

  assign pin_raw = {media_n, batt_good, ext_supply_n, ext_irq_n, fiq_n};

  intr_sync #(.W(PIN_W), .DEPTH(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst(rst), .d(pin_raw), .q(pin_s)
  );

  assign batt_cond = pin_s[P_SUPPLY] & ~pin_s[P_BGOOD];

  intr_deglitch #(.RST_VAL(1'b0)) u_dg_batt (
    .clk(clk), .rst(rst), .en(slow_tick), .d(batt_cond),
    .lvl(batt_lvl), .rise(batt_rise)
  );

  intr_deglitch #(.RST_VAL(1'b1)) u_dg_media (
    .clk(clk), .rst(rst), .en(slow_tick), .d(pin_s[P_MEDIA]),
    .lvl(med_lvl), .rise(med_rise)
  );

  always_comb begin
    lat_set         = '0;
    lat_set[E_BATT] = batt_lvl;
    lat_set[E_MEDIA] = med_rise;
    lat_set[E_CODEC] = codec_set;
    lat_set[E_TICK] = hz_tick;
    lat_set[E_TMR1] = tmr1_set;
    lat_set[E_TMR2] = tmr2_set;
    lat_set[E_RTC]  = rtc_set;
    lat_hold        = '0;
    lat_hold[E_BATT] = standby;
  end

  intr_latch #(.N(NUM_LAT)) u_lat (
    .clk(clk), .rst(rst), .set(lat_set), .clr(eoi),
    .hold_off(lat_hold), .q(lat_q)
  );

  assign wdog_set = hz_tick & lat_q[E_TICK];

  intr_latch #(.N(1)) u_wdog (
    .clk(clk), .rst(rst), .set(wdog_set), .clr(eoi[E_TICK]),
    .hold_off(standby), .q(wdog_q)
  );

  always_comb begin
    raw          = '0;
    raw[B_FIQ]   = ~pin_s[P_FIQ];
    raw[B_BATT]  = lat_q[E_BATT];
    raw[B_WDOG]  = wdog_q;
    raw[B_MEDIA] = lat_q[E_MEDIA];
    raw[B_CODEC] = lat_q[E_CODEC];
    for (int i = 0; i < NUM_EXT; i++) raw[B_EXT1+i] = ~pin_s[P_EXT+i];
    raw[B_TMR1]  = lat_q[E_TMR1];
    raw[B_TMR2]  = lat_q[E_TMR2];
    raw[B_RTC]   = lat_q[E_RTC];
    raw[B_TICK]  = lat_q[E_TICK];
    raw[B_UTX]   = uart_tx_irq;
    raw[B_URX]   = uart_rx_irq;
    raw[B_UMS]   = uart_ms_irq;
    raw[B_SSI]   = ssi_eot_irq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      fiq_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= raw;
      fiq_q    <= |raw[B_FIQ_TOP:B_FIQ];
      irq_q    <= |raw[STAT_W-1:B_FIQ_TOP+1];
    end
  end

  assign status = {{(BUS_W-STAT_W){1'b0}}, status_q};
  assign fiq    = fiq_q;
  assign irq    = irq_q;

  // R2
  fiq_pin_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_s[P_FIQ] |=> status_q[B_FIQ]);

  // R6
  media_edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(med_lvl) |=> lat_q[E_MEDIA]);

  // R8
  wdog_on_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (hz_tick && lat_q[E_TICK] && !standby) |=> wdog_q);

  // R9
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    standby |=> (!wdog_q && !lat_q[E_BATT]));
endmodule

// File: tb/intr_status_agg_bench.sv
module intr_status_agg_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_tick = 0, hz_tick = 0, standby = 0;
  logic fiq_n = 1;
  logic [2:0] ext_irq_n = 3'b111;
  logic ext_supply_n = 0, batt_good = 1, media_n = 1;
  logic codec_set = 0, tmr1_set = 0, tmr2_set = 0, rtc_set = 0;
  logic uart_tx_irq = 0, uart_rx_irq = 0, uart_ms_irq = 0, ssi_eot_irq = 0;
  logic [6:0] eoi = '0;
  logic [31:0] status;
  logic fiq, irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  intr_status_agg u_intr_status_agg (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .hz_tick(hz_tick),
    .standby(standby), .fiq_n(fiq_n), .ext_irq_n(ext_irq_n),
    .ext_supply_n(ext_supply_n), .batt_good(batt_good), .media_n(media_n),
    .codec_set(codec_set), .tmr1_set(tmr1_set), .tmr2_set(tmr2_set),
    .rtc_set(rtc_set), .uart_tx_irq(uart_tx_irq), .uart_rx_irq(uart_rx_irq),
    .uart_ms_irq(uart_ms_irq), .ssi_eot_irq(ssi_eot_irq), .eoi(eoi),
    .status(status), .fiq(fiq), .irq(irq)
  );

  // {fiq_n, ext_irq_n[2:0], {ssi,ms,rx,tx}, expected status[15:0]}
  localparam logic [23:0] VEC [9] = '{
    {1'b1, 3'b111, 4'b0000, 16'h0000},
    {1'b0, 3'b111, 4'b0000, 16'h0001},
    {1'b1, 3'b110, 4'b0000, 16'h0020},
    {1'b1, 3'b101, 4'b0000, 16'h0040},
    {1'b1, 3'b011, 4'b0000, 16'h0080},
    {1'b1, 3'b111, 4'b0001, 16'h1000},
    {1'b1, 3'b111, 4'b1010, 16'hA000},
    {1'b0, 3'b000, 4'b1111, 16'hF0E1},
    {1'b1, 3'b010, 4'b0100, 16'h40A0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input logic [15:0] exp, input string req);
    check(status, {16'h0, exp}, req);
    check({31'h0, fiq}, {31'h0, |exp[3:0]}, {req, " R12 fiq"});
    check({31'h0, irq}, {31'h0, |exp[15:4]}, {req, " R12 irq"});
  endtask

  task automatic slow_pulse();
    slow_tick = 1; step(1); slow_tick = 0; step(3);
  endtask

  task automatic pulse_eoi(input logic [6:0] v);
    eoi = v; step(1); eoi = '0; step(4);
  endtask

  task automatic pulse_hz();
    hz_tick = 1; step(1); hz_tick = 0; step(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(4);
    // R13 during reset
    check_all(16'h0000, "R13 in reset");
    rst = 0;
    step(4);
    check_all(16'h0000, "R13 after reset");

    // R1 R2 R3 R11 table walk
    for (int i = 0; i < 9; i++) begin
      logic [3:0] lv;
      logic [15:0] ex;
      {fiq_n, ext_irq_n, lv, ex} = VEC[i];
      {ssi_eot_irq, uart_ms_irq, uart_rx_irq, uart_tx_irq} = lv;
      step(4);
      check_all(ex, "R1 R2 R3 R11 vector");
    end
    fiq_n = 1; ext_irq_n = 3'b111;
    {ssi_eot_irq, uart_ms_irq, uart_rx_irq, uart_tx_irq} = 4'b0000;
    step(4);
    check_all(16'h0000, "R3 pins released");

    // R10 latched pulses
    codec_set = 1; step(1); codec_set = 0; step(4);
    check_all(16'h0010, "R10 codec");
    tmr1_set = 1; tmr2_set = 1; rtc_set = 1; step(1);
    tmr1_set = 0; tmr2_set = 0; rtc_set = 0; step(4);
    check_all(16'h0710, "R10 timers rtc");
    pulse_eoi(7'b0000100);
    check_all(16'h0700, "R10 codec clear");
    pulse_eoi(7'b1110000);
    check_all(16'h0000, "R10 timers clear");
    codec_set = 1; eoi = 7'b0000100; step(1);
    codec_set = 0; eoi = '0; step(4);
    check_all(16'h0010, "R10 set beats clear");
    pulse_eoi(7'b0000100);
    check_all(16'h0000, "R10 final clear");

    // R8 tick and watchdog
    pulse_hz();
    check_all(16'h0800, "R8 tick");
    pulse_hz();
    check_all(16'h0804, "R8 watchdog");
    pulse_eoi(7'b0001000);
    check_all(16'h0000, "R8 clear both");

    // R9 standby
    pulse_hz(); pulse_hz();
    check_all(16'h0804, "R9 pre standby");
    standby = 1; step(4);
    check_all(16'h0800, "R9 wdog forced low");
    pulse_hz();
    check_all(16'h0800, "R9 no wdog in standby");
    standby = 0; pulse_eoi(7'b0001000);
    check_all(16'h0000, "R9 recover");

    // R4 supply present blocks battery low
    batt_good = 0; step(3);
    slow_pulse(); slow_pulse(); step(2);
    check_all(16'h0000, "R4 supply present");
    // R4 R5 condition held two samples
    ext_supply_n = 1; step(3);
    slow_pulse(); slow_pulse(); step(2);
    check_all(16'h0002, "R4 R5 battery low");
    standby = 1; step(4);
    check_all(16'h0000, "R9 battery forced low");
    standby = 0; step(4);
    check_all(16'h0002, "R9 battery back");
    batt_good = 1; step(3);
    slow_pulse(); slow_pulse(); step(2);
    check_all(16'h0002, "R7 latched after release");
    pulse_eoi(7'b0000001);
    check_all(16'h0000, "R7 clear");
    // R5 single-sample glitch
    batt_good = 0; step(3);
    slow_pulse();
    batt_good = 1; step(3);
    slow_pulse(); slow_pulse(); step(2);
    check_all(16'h0000, "R5 glitch rejected");
    ext_supply_n = 0;

    // R6 media
    media_n = 0; step(3);
    slow_pulse(); slow_pulse(); step(2);
    check_all(16'h0000, "R6 falling ignored");
    media_n = 1; step(3);
    slow_pulse(); slow_pulse(); step(2);
    check_all(16'h0008, "R6 rising latched");
    slow_pulse(); slow_pulse(); step(2);
    check_all(16'h0008, "R6 holds");
    pulse_eoi(7'b0000010);
    check_all(16'h0000, "R6 clear");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule